// File: doc/BRIEF.md
# Auto-Start Response Timeout Timer

This block measures how long a contactless reader waits for a card to answer. When a transmission finishes, the timer loads a programmed reload count and counts down once per tick. The tick comes from the reference clock through a programmable divider. If the count runs out before any reply begins, the block raises a sticky timeout interrupt flag. If a reply starts first, the timer stops quietly and the count stays frozen where it was.

The tick period is `2P + 1` reference cycles. P is a 12-bit divider value built from a 4-bit high field and an 8-bit low field. With a 13.56 MHz reference, P = 169 gives a 25 µs tick, and a reload of 1000 then gives a 25 ms timeout. Automatic starting can be turned off, in which case the end of a transmission is ignored. The interrupt flag stays set until system logic pulses the clear input.

Top module: `resp_timeout_timer`

## Requirements
- R1: The timer ticks once every `2P + 1` clock cycles, where P = {presc_hi, presc_lo} (presc_hi is the upper 4 bits). While running, `count` drops by one on each tick. With P = 0 it drops on every clock.
- R2: A `tx_end` pulse while `auto_start` is high and `reload` is nonzero loads `reload` into `count` on that clock edge. It also starts the timer with the tick divider cleared, so the first decrement comes `2P + 1` cycles after the load edge.
- R3: `count` goes from 1 to 0 on the edge exactly `reload × (2P + 1)` cycles after the load edge. On that same edge `timer_irq` rises and the timer stops, so `count` stays 0.
- R4: `timer_irq` stays set until a pulse on `irq_clear`. The clear takes effect on the next edge.
- R5: If a clear and an expiry fall on the same edge, `timer_irq` ends up set.
- R6: A `rx_start` pulse stops a running timer without setting `timer_irq`. It freezes `count` at its value from before that edge, even if a tick falls on the same edge.
- R7: While `auto_start` is low, `tx_end` is ignored. `count` and `timer_irq` keep their values.
- R8: A start while the timer is already running reloads `count` and restarts the divider. The expiry then falls `reload × (2P + 1)` cycles after the new load edge.
- R9: A start with `reload` = 0 stops the timer and sets `count` to 0, and it never raises `timer_irq`.
- R10: When a start and a `rx_start` arrive on the same edge, the start wins.
- R11: After reset, `timer_irq` is 0, `count` is 0 and the timer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| presc_hi | input | 4 | Upper part of divider value P |
| presc_lo | input | 8 | Lower part of divider value P |
| reload | input | 16 | Count loaded at start |
| auto_start | input | 1 | Start automatically on end of transmission |
| tx_end | input | 1 | One-cycle pulse: transmission finished |
| rx_start | input | 1 | One-cycle pulse: a response has begun |
| irq_clear | input | 1 | One-cycle pulse: clear the interrupt flag |
| timer_irq | output | 1 | Sticky timeout interrupt request |
| count | output | 16 | Current timer count |

## Verification
The load appears on `count` right after the start edge. Each decrement lands `2P + 1` edges after the previous one, and `timer_irq` rises `reload × (2P + 1)` edges after the load edge. The driver task computes that edge number at start time and pushes it into a queue. A monitor counts edges and compares every rising edge of `timer_irq` with the queue head. It flags early, late or unexpected rises. Count values are sampled on falling edges at positions counted from the load edge, and the stop and ignore cases watch `count` and the flag for dozens of cycles afterward.

// File: rtl/rtt_pkg.sv
package rtt_pkg;
    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_LOAD,
        CMD_ZERO,
        CMD_HALT,
        CMD_STEP
    } cnt_cmd_e;
endpackage

// File: rtl/rtt_prescaler.sv
module rtt_prescaler #(
    parameter int PRE_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             restart,
    input  logic [PRE_W-1:0] presc,
    output logic             tick
);
    localparam int DIV_W = PRE_W + 1;

    typedef struct packed {
        logic [DIV_W-1:0] div;
    } pre_st_t;

    pre_st_t s_d, s_q;
    logic [DIV_W-1:0] limit;

    always_comb begin
        limit = {presc, 1'b0};
        tick  = enable && !restart && (s_q.div >= limit);
        s_d   = s_q;
        if (restart || !enable || tick) begin
            s_d.div = '0;
        end else begin
            s_d.div = s_q.div + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R1: divider is held cleared while the timer is idle
    p_idle_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !restart) |=> (s_q.div == '0));
endmodule

// File: rtl/rtt_counter.sv
module rtt_counter
    import rtt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             stop,
    input  logic             tick,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output logic             running,
    output logic             expire
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             run;
    } cnt_st_t;

    cnt_st_t  s_d, s_q;
    cnt_cmd_e cmd;

    always_comb begin
        cmd = CMD_NONE;
        if (start)                 cmd = (reload != '0) ? CMD_LOAD : CMD_ZERO;
        else if (stop)             cmd = CMD_HALT;
        else if (s_q.run && tick)  cmd = CMD_STEP;

        s_d    = s_q;
        expire = 1'b0;
        unique case (cmd)
            CMD_LOAD: begin
                s_d.cnt = reload;
                s_d.run = 1'b1;
            end
            CMD_ZERO: begin
                s_d.cnt = '0;
                s_d.run = 1'b0;
            end
            CMD_HALT: s_d.run = 1'b0;
            CMD_STEP: begin
                s_d.cnt = s_q.cnt - CNT_W'(1);
                if (s_q.cnt == CNT_W'(1)) begin
                    s_d.run = 1'b0;
                    expire  = 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign count   = s_q.cnt;
    assign running = s_q.run;

    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && reload != '0) |=> (running && count == $past(reload)));

    p_stop_at_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (count != '0));

    p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick && !start && !stop) |=> (count == $past(count) - CNT_W'(1)));

    p_rx_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !start) |=> (!running && count == $past(count)));

    p_zero_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && reload == '0) |=> (!running && count == '0));
endmodule

// File: rtl/rtt_irq_flag.sv
module rtt_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    typedef struct packed {
        logic irq;
    } irq_st_t;

    irq_st_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.irq = set | (s_q.irq & ~clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign flag = s_q.irq;

    p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);

    p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> flag);
endmodule

// File: rtl/resp_timeout_timer.sv
module resp_timeout_timer #(
    parameter int PRE_HI_W = 4,
    parameter int PRE_LO_W = 8,
    parameter int CNT_W    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PRE_HI_W-1:0] presc_hi,
    input  logic [PRE_LO_W-1:0] presc_lo,
    input  logic [CNT_W-1:0]    reload,
    input  logic                auto_start,
    input  logic                tx_end,
    input  logic                rx_start,
    input  logic                irq_clear,
    output logic                timer_irq,
    output logic [CNT_W-1:0]    count
);
    localparam int PRE_W = PRE_HI_W + PRE_LO_W;

    logic             start;
    logic             running;
    logic             tick;
    logic             expire;
    logic [PRE_W-1:0] presc;

    assign start = auto_start & tx_end;
    assign presc = {presc_hi, presc_lo};

    rtt_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (running),
        .restart(start),
        .presc  (presc),
        .tick   (tick)
    );

    rtt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .stop   (rx_start),
        .tick   (tick),
        .reload (reload),
        .count  (count),
        .running(running),
        .expire (expire)
    );

    rtt_irq_flag u_irq (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (expire),
        .clr  (irq_clear),
        .flag (timer_irq)
    );

    p_expiry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick && count == CNT_W'(1) && !start && !rx_start)
        |=> (timer_irq && count == '0 && !running));

    p_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_start && !rx_start && !running) |=> (count == $past(count)));
endmodule

// File: tb/resp_timeout_timer_bench.sv
`timescale 1ns/1ps
module resp_timeout_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  presc_hi = '0;
    logic [7:0]  presc_lo = '0;
    logic [15:0] reload = '0;
    logic        auto_start = 1'b0;
    logic        tx_end = 1'b0;
    logic        rx_start = 1'b0;
    logic        irq_clear = 1'b0;
    logic        timer_irq;
    logic [15:0] count;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    int exp_q[$];
    bit done = 0;
    logic irq_prev = 1'b0;

    always #2.5 clk = ~clk;

    resp_timeout_timer u_resp_timeout_timer (
        .clk(clk), .rst_n(rst_n), .presc_hi(presc_hi), .presc_lo(presc_lo),
        .reload(reload), .auto_start(auto_start), .tx_end(tx_end),
        .rx_start(rx_start), .irq_clear(irq_clear),
        .timer_irq(timer_irq), .count(count)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check_eq(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Monitor: compare each rise of timer_irq against the scoreboard head
    always @(negedge clk) begin
        if (rst_n) begin
            if (timer_irq && !irq_prev) begin
                if (exp_q.size() == 0) begin
                    check_eq("R3/R6/R9 unexpected irq rise at cycle", cyc, -1);
                end else begin
                    check_eq("R3 irq rise cycle", cyc, exp_q.pop_front());
                end
            end else if (exp_q.size() != 0 && cyc > exp_q[0]) begin
                check_eq("R3 irq missing, due at cycle", cyc, exp_q.pop_front());
            end
            irq_prev = timer_irq;
        end
    end

    // Driver: called at a falling edge; the start edge is edge number cyc+1
    task automatic do_start(input int p, input int r, input bit expect_irq, input bit with_rx);
        presc_hi = p[11:8];
        presc_lo = p[7:0];
        reload   = r[15:0];
        tx_end   = 1'b1;
        rx_start = with_rx;
        if (expect_irq) exp_q.push_back(cyc + 1 + r * (2 * p + 1));
        @(negedge clk);
        tx_end   = 1'b0;
        rx_start = 1'b0;
        if (auto_start && r != 0) check_eq("R2 count loaded at start", count, r);
    endtask

    task automatic wait_expire();
        for (int i = 0; i < 20000 && exp_q.size() != 0; i++) @(negedge clk);
        @(negedge clk);
        check_eq("R3 scoreboard drained", exp_q.size(), 0);
    endtask

    task automatic clear_irq();
        irq_clear = 1'b1;
        @(negedge clk);
        irq_clear = 1'b0;
        check_eq("R4 irq cleared by pulse", timer_irq, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        nchk++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check_eq("R11 reset irq", timer_irq, 0);
        check_eq("R11 reset count", count, 0);
        rst_n = 1'b1;
        @(negedge clk);
        auto_start = 1'b1;

        // R1 with P=0, R3 expiry and stop
        do_start(0, 5, 1, 0);
        @(negedge clk);
        check_eq("R1 P=0 decrement every clock", count, 4);
        wait_expire();
        check_eq("R3 count zero after expiry", count, 0);
        repeat (5) @(negedge clk);
        check_eq("R4 irq still set", timer_irq, 1);
        check_eq("R3 timer stopped at zero", count, 0);
        clear_irq();

        // R1 tick spacing with P=2
        do_start(2, 3, 1, 0);
        repeat (4) @(negedge clk);
        check_eq("R1 no decrement before 2P+1", count, 3);
        @(negedge clk);
        check_eq("R1 decrement at 2P+1", count, 2);
        wait_expire();
        clear_irq();

        // R1 larger divider values, both fields in use
        do_start(169, 3, 1, 0);
        wait_expire();
        clear_irq();
        do_start(4095, 1, 1, 0);
        wait_expire();
        clear_irq();

        // R5 clear on the expiry edge
        do_start(0, 4, 1, 0);
        repeat (3) @(negedge clk);
        irq_clear = 1'b1;
        @(negedge clk);
        irq_clear = 1'b0;
        check_eq("R5 set wins over clear", timer_irq, 1);
        clear_irq();

        // R6 rx_start stops the timer
        do_start(1, 4, 0, 0);
        repeat (4) @(negedge clk);
        rx_start = 1'b1;
        @(negedge clk);
        rx_start = 1'b0;
        check_eq("R6 count frozen at stop", count, 3);
        repeat (40) @(negedge clk);
        check_eq("R6 count still frozen", count, 3);
        check_eq("R6 no irq after stop", timer_irq, 0);

        // R7 auto start disabled
        auto_start = 1'b0;
        do_start(0, 7, 0, 0);
        repeat (20) @(negedge clk);
        check_eq("R7 tx_end ignored, count unchanged", count, 3);
        check_eq("R7 tx_end ignored, no irq", timer_irq, 0);
        auto_start = 1'b1;

        // R8 restart while running
        do_start(0, 6, 0, 0);
        repeat (2) @(negedge clk);
        check_eq("R8 running before restart", count, 4);
        do_start(0, 6, 1, 0);
        wait_expire();
        clear_irq();

        // R9 zero reload halts and stays quiet
        do_start(0, 9, 0, 0);
        repeat (2) @(negedge clk);
        do_start(0, 0, 0, 0);
        check_eq("R9 count zero", count, 0);
        repeat (30) @(negedge clk);
        check_eq("R9 no irq", timer_irq, 0);
        check_eq("R9 count still zero", count, 0);

        // R10 start beats rx_start
        do_start(0, 2, 1, 1);
        wait_expire();
        check_eq("R10 irq after simultaneous start/stop", timer_irq, 1);
        clear_irq();

        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule